// File: doc/BRIEF.md
# Mesh Router Output Port Selector

This block decides where a packet leaves one router of a two-dimensional mesh. From the coordinates of the router it sits in and the packet's destination, it works out the set of output directions that move the packet closer to its target. In adaptive mode it works under a turn restriction that makes westward travel the first leg of any route. Every permitted direction is reported as a bit of a one-hot-per-port vector. When more than one direction is permitted, the block compares how many free slots each candidate's downstream buffer has and picks the least congested one.

A mode input replaces the adaptive behaviour with plain column-first routing: the packet travels along X until it reaches the destination column, then along Y. The admissible set is combinational. The chosen port is captured in a register when a head flit is presented while the unit is idle. It stays fixed until the switch signals that the route is finished, so every later flit of the packet follows the head.

Port vector encoding, used on every port vector: bit 0 local, bit 1 east (X rising), bit 2 west (X falling), bit 3 north (Y rising), bit 4 south (Y falling).

Top module: `mesh_route_sel`

## Requirements
- R1: When the destination equals the current node, in either mode, the admissible set is exactly the local bit (bit 0) and the selected port is local.
- R2: With `det_mode`=1, the admissible set holds exactly one bit. It is east (bit 1) or west (bit 2) while the X coordinates differ, and north (bit 3) or south (bit 4) only once they match.
- R3: With `det_mode`=0, a destination with smaller X than the current node yields west (bit 2) alone, whatever the Y difference.
- R4: With `det_mode`=0, west never appears in the admissible set together with any other bit, so no route turns from a vertical direction into west.
- R5: With `det_mode`=0, a destination with larger X and different Y admits both east and the vertical direction that reduces the Y distance.
- R6: Only profitable directions are admitted: east only if destination X is larger, north only if destination Y is larger, south only if destination Y is smaller.
- R7: When two ports are admissible, the captured choice is the one whose downstream buffer has more free slots. Free slots are `DEPTH` minus occupancy, saturating at zero when the occupancy reaches or exceeds `DEPTH`.
- R8: When the two candidates have equal free slots, the X-dimension port is chosen.
- R9: A head flit (`head_valid`=1) seen at a clock edge while `sel_valid`=0 sets `sel_valid` and loads `sel_port` at that edge.
- R10: While `sel_valid`=1 and `route_done`=0, `sel_port` stays constant. Changes on destination, occupancy, mode or `head_valid` have no effect on it.
- R11: `route_done`=1 while `sel_valid`=1 clears `sel_valid` at the next edge. `sel_port` reads zero whenever `sel_valid`=0.
- R12: After reset, `sel_valid`=0 and `sel_port`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_mode | input | 1 | 1 = column-first deterministic routing, 0 = adaptive west-first |
| head_valid | input | 1 | A head flit with valid destination is presented |
| route_done | input | 1 | Releases the held selection |
| cur_x | input | COORD_W | X coordinate of this router |
| cur_y | input | COORD_W | Y coordinate of this router |
| dst_x | input | COORD_W | Destination X coordinate |
| dst_y | input | COORD_W | Destination Y coordinate |
| occ_east | input | OCC_W | Occupancy of the east downstream buffer |
| occ_west | input | OCC_W | Occupancy of the west downstream buffer |
| occ_north | input | OCC_W | Occupancy of the north downstream buffer |
| occ_south | input | OCC_W | Occupancy of the south downstream buffer |
| adm_set | output | 5 | Admissible output directions (encoding above) |
| sel_port | output | 5 | Held selected output, one bit set while valid |
| sel_valid | output | 1 | A selection is held |

## Verification
The hardest case to reach is a selection that must stay fixed while everything that fed it changes under it. To reach it, the stimulus captures a route, then swaps the destination, the mode and the congestion figures so that a fresh evaluation would pick a different port. It keeps `head_valid` high and withholds `route_done` for several cycles, comparing the held port each cycle. The congestion comparison is also pushed to its edges. One test gives equal free counts to check the X preference. Another gives occupancies at and beyond the buffer depth, so both candidates saturate to zero free slots and the tie rule must still hold.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   localparam int unsigned NPORT   = 5;
   localparam int unsigned PI_LOC  = 0;
   localparam int unsigned PI_EAST = 1;
   localparam int unsigned PI_WEST = 2;
   localparam int unsigned PI_NRTH = 3;
   localparam int unsigned PI_STH  = 4;
   // index of each remote direction in the packed occupancy array
   localparam int unsigned NDIR    = 4;
   localparam int unsigned DI_E    = 0;
   localparam int unsigned DI_W    = 1;
   localparam int unsigned DI_N    = 2;
   localparam int unsigned DI_S    = 3;
   typedef logic [NPORT-1:0] portvec_t;

   function automatic portvec_t port_bit(input int unsigned idx);
      portvec_t v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/mrs_admit.sv
module mrs_admit
   import mrs_pkg::*;
#(
   parameter int unsigned COORD_W     = 3,
   parameter bit          ADAPTIVE_EN = 1'b1
) (
   input  logic               det_mode,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   output portvec_t           adm
);
   logic go_e, go_w, go_n, go_s, use_det;
   portvec_t v_det, v_ada;

   assign go_e = dst_x > cur_x;
   assign go_w = dst_x < cur_x;
   assign go_n = dst_y > cur_y;
   assign go_s = dst_y < cur_y;

   generate
      if (ADAPTIVE_EN) begin : g_mode_sel
         assign use_det = det_mode;
      end else begin : g_det_only
         assign use_det = 1'b1;
      end
   endgenerate

   // column-first: finish X, then Y, then deliver
   always_comb begin
      if (go_w)      v_det = port_bit(PI_WEST);
      else if (go_e) v_det = port_bit(PI_EAST);
      else if (go_n) v_det = port_bit(PI_NRTH);
      else if (go_s) v_det = port_bit(PI_STH);
      else           v_det = port_bit(PI_LOC);
   end

   // west-first: westward legs are taken before any other, alone
   always_comb begin
      v_ada = '0;
      if (go_w) begin
         v_ada[PI_WEST] = 1'b1;
      end else if (!go_e && !go_n && !go_s) begin
         v_ada[PI_LOC] = 1'b1;
      end else begin
         v_ada[PI_EAST] = go_e;
         v_ada[PI_NRTH] = go_n;
         v_ada[PI_STH]  = go_s;
      end
   end

   assign adm = use_det ? v_det : v_ada;
endmodule

// File: rtl/mrs_select.sv
module mrs_select
   import mrs_pkg::*;
#(
   parameter int unsigned OCC_W = 3,
   parameter int unsigned DEPTH = 4
) (
   input  portvec_t                     adm,
   input  logic [NDIR-1:0][OCC_W-1:0]   occ,
   output portvec_t                     pick
);
   localparam int unsigned FW = OCC_W + 1;
   localparam logic [FW-1:0] DEPTH_V = FW'(DEPTH);

   logic [NDIR-1:0][FW-1:0] free_n;

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_free
         logic [FW-1:0] occ_x;
         assign occ_x     = {1'b0, occ[d]};
         assign free_n[d] = (occ_x >= DEPTH_V) ? '0 : (DEPTH_V - occ_x);
      end
   endgenerate

   logic          has_x, has_y;
   logic [FW-1:0] fx, fy;
   portvec_t      px, py;

   always_comb begin
      has_x = adm[PI_EAST] | adm[PI_WEST];
      has_y = adm[PI_NRTH] | adm[PI_STH];
      px    = adm[PI_EAST] ? port_bit(PI_EAST) : port_bit(PI_WEST);
      fx    = adm[PI_EAST] ? free_n[DI_E] : free_n[DI_W];
      py    = adm[PI_NRTH] ? port_bit(PI_NRTH) : port_bit(PI_STH);
      fy    = adm[PI_NRTH] ? free_n[DI_N] : free_n[DI_S];
      if (has_x && has_y) pick = (fy > fx) ? py : px;
      else                pick = adm;
   end
endmodule

// File: rtl/mrs_hold.sv
module mrs_hold
   import mrs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     head_valid,
   input  logic     route_done,
   input  portvec_t pick,
   output portvec_t sel_port,
   output logic     sel_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_port  <= '0;
      end else if (sel_valid) begin
         if (route_done) begin
            sel_valid <= 1'b0;
            sel_port  <= '0;
         end
      end else if (head_valid) begin
         sel_valid <= 1'b1;
         sel_port  <= pick;
      end
   end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
   import mrs_pkg::*;
#(
   parameter int unsigned COORD_W     = 3,
   parameter int unsigned OCC_W       = 3,
   parameter int unsigned DEPTH       = 4,
   parameter bit          ADAPTIVE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               det_mode,
   input  logic               head_valid,
   input  logic               route_done,
   input  logic [COORD_W-1:0] cur_x,
   input  logic [COORD_W-1:0] cur_y,
   input  logic [COORD_W-1:0] dst_x,
   input  logic [COORD_W-1:0] dst_y,
   input  logic [OCC_W-1:0]   occ_east,
   input  logic [OCC_W-1:0]   occ_west,
   input  logic [OCC_W-1:0]   occ_north,
   input  logic [OCC_W-1:0]   occ_south,
   output logic [4:0]         adm_set,
   output logic [4:0]         sel_port,
   output logic               sel_valid
);
   generate
      if (COORD_W < 1 || COORD_W > 16) begin : g_bad_coord
         $error("COORD_W out of range");
      end
      if (DEPTH < 1 || DEPTH >= (1 << OCC_W)) begin : g_bad_depth
         $error("DEPTH must be at least 1 and fit in OCC_W bits");
      end
   endgenerate

   portvec_t adm_w, pick_w, sel_w;
   logic [NDIR-1:0][OCC_W-1:0] occ_pk;

   always_comb begin
      occ_pk       = '0;
      occ_pk[DI_E] = occ_east;
      occ_pk[DI_W] = occ_west;
      occ_pk[DI_N] = occ_north;
      occ_pk[DI_S] = occ_south;
   end

   mrs_admit #(.COORD_W(COORD_W), .ADAPTIVE_EN(ADAPTIVE_EN)) u_admit (
      .det_mode (det_mode),
      .cur_x    (cur_x),
      .cur_y    (cur_y),
      .dst_x    (dst_x),
      .dst_y    (dst_y),
      .adm      (adm_w)
   );

   mrs_select #(.OCC_W(OCC_W), .DEPTH(DEPTH)) u_select (
      .adm  (adm_w),
      .occ  (occ_pk),
      .pick (pick_w)
   );

   mrs_hold u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (head_valid),
      .route_done (route_done),
      .pick       (pick_w),
      .sel_port   (sel_w),
      .sel_valid  (sel_valid)
   );

   assign adm_set  = adm_w;
   assign sel_port = sel_w;
endmodule

// File: rtl/mrs_chk.sv
module mrs_chk #(
   parameter int unsigned COORD_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               det_mode,
   input logic               head_valid,
   input logic               route_done,
   input logic [COORD_W-1:0] cur_x,
   input logic [COORD_W-1:0] cur_y,
   input logic [COORD_W-1:0] dst_x,
   input logic [COORD_W-1:0] dst_y,
   input logic [4:0]         adm_set,
   input logic [4:0]         sel_port,
   input logic               sel_valid
);
   assert_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_x == dst_x && cur_y == dst_y) |-> adm_set == 5'b00001);

   assert_det_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      det_mode |-> $countones(adm_set) == 1);

   assert_west_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_mode && adm_set[2]) |-> $countones(adm_set) == 1);

   assert_no_east_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adm_set[1] |-> dst_x > cur_x);

   assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_valid && head_valid) |=> sel_valid && $countones(sel_port) == 1
                                     && (sel_port & $past(adm_set)) != 5'b0);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !route_done) |=> sel_valid && $stable(sel_port));

   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && route_done) |=> !sel_valid);

   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> sel_port == 5'b0);
endmodule

bind mesh_route_sel mrs_chk #(.COORD_W(COORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .det_mode   (det_mode),
   .head_valid (head_valid),
   .route_done (route_done),
   .cur_x      (cur_x),
   .cur_y      (cur_y),
   .dst_x      (dst_x),
   .dst_y      (dst_y),
   .adm_set    (adm_set),
   .sel_port   (sel_port),
   .sel_valid  (sel_valid)
);

// File: tb/sim_mesh_route_sel.sv
`timescale 1ns/1ps
module sim_mesh_route_sel;
   localparam logic [4:0] L = 5'b00001, E = 5'b00010, W = 5'b00100,
                          N = 5'b01000, S = 5'b10000;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       det_mode = 1'b0, head_valid = 1'b0, route_done = 1'b0;
   logic [2:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
   logic [2:0] occ_east = '0, occ_west = '0, occ_north = '0, occ_south = '0;
   logic [4:0] adm_set, sel_port;
   logic       sel_valid;
   int         n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   mesh_route_sel u0 (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_occ(input int e, input int w, input int n, input int s);
      occ_east = 3'(e); occ_west = 3'(w); occ_north = 3'(n); occ_south = 3'(s);
   endtask

   // drive one head flit, check the admissible set, capture, release
   task automatic route(input bit dm, input int cx, input int cy, input int dx, input int dy,
                        input logic [4:0] exp_adm, input logic [4:0] exp_sel, input string req);
      @(negedge clk);
      det_mode = dm; cur_x = 3'(cx); cur_y = 3'(cy); dst_x = 3'(dx); dst_y = 3'(dy);
      head_valid = 1'b1;
      #1;
      chk(adm_set == exp_adm, {req, " adm"}, adm_set, exp_adm);
      @(negedge clk);
      head_valid = 1'b0;
      chk(sel_valid == 1'b1, {req, " R9 valid"}, sel_valid, 1);
      chk(sel_port == exp_sel, {req, " sel"}, sel_port, exp_sel);
      route_done = 1'b1;
      @(negedge clk);
      route_done = 1'b0;
      chk(sel_valid == 1'b0 && sel_port == 5'b0, "R11 release", {sel_valid, sel_port}, 0);
   endtask

   task automatic t_reset;
      chk(sel_valid == 1'b0, "R12 valid", sel_valid, 0);
      chk(sel_port == 5'b0, "R12 port", sel_port, 0);
   endtask

   task automatic t_local;
      set_occ(0, 0, 0, 0);
      route(1'b0, 3, 3, 3, 3, L, L, "R1 adaptive");
      route(1'b1, 6, 0, 6, 0, L, L, "R1 det");
   endtask

   task automatic t_det;
      route(1'b1, 2, 2, 5, 6, E, E, "R2 east first");
      route(1'b1, 5, 2, 5, 0, S, S, "R2 then south");
      route(1'b1, 5, 5, 1, 7, W, W, "R2 west");
      route(1'b1, 0, 0, 0, 7, N, N, "R2 north");
   endtask

   task automatic t_adaptive;
      set_occ(0, 7, 0, 0);
      route(1'b0, 5, 5, 1, 7, W, W, "R3 R4 west only");
      route(1'b0, 4, 4, 4, 0, S, S, "R6 south only");
      route(1'b0, 0, 0, 7, 0, E, E, "R6 east only");
      set_occ(3, 0, 0, 0);
      route(1'b0, 1, 1, 4, 5, E | N, N, "R5 R7 north freer");
      set_occ(0, 0, 0, 2);
      route(1'b0, 1, 6, 4, 2, E | S, E, "R5 R7 east freer");
   endtask

   task automatic t_tie;
      set_occ(1, 0, 1, 0);
      route(1'b0, 1, 1, 4, 5, E | N, E, "R8 equal free");
      set_occ(7, 0, 4, 0);
      route(1'b0, 1, 1, 4, 5, E | N, E, "R7 R8 saturated");
      set_occ(4, 0, 0, 3);
      route(1'b0, 2, 6, 7, 1, E | S, S, "R7 east full");
   endtask

   task automatic t_hold;
      set_occ(3, 0, 0, 0);
      @(negedge clk);
      det_mode = 1'b0; cur_x = 3'd1; cur_y = 3'd1; dst_x = 3'd4; dst_y = 3'd5;
      head_valid = 1'b1;
      @(negedge clk);
      chk(sel_port == N, "R10 captured", sel_port, N);
      // everything changes so a new evaluation would pick east or west
      set_occ(0, 0, 4, 4);
      dst_x = 3'd0; dst_y = 3'd1; det_mode = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(sel_valid == 1'b1 && sel_port == N, "R10 held", sel_port, N);
      end
      route_done = 1'b1; head_valid = 1'b0;
      @(negedge clk);
      route_done = 1'b0;
      chk(sel_valid == 1'b0, "R11 cleared", sel_valid, 0);
      chk(sel_port == 5'b0, "R11 idle zero", sel_port, 0);
   endtask

   initial begin
      #1000000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_local;
      t_det;
      t_adaptive;
      t_tie;
      t_hold;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule